// File: doc/BRIEF.md
# Width-Matching RAM Port Adapter

This block puts a single external data port in front of a 36-bit-wide synchronous RAM. The same port can run as a full 36-bit bus, as an 18-bit bus or as a 9-bit bus. Two configuration pins choose the width. They are treated as static strapping and change only while the port is idle. In the narrow widths, one or two extra low-order address inputs pick the slice of the stored 36-bit word that moves on the bus. A narrow write updates only that slice. A narrow read returns the slice on the lowest lanes of the port.

The port is divided into four 9-bit lanes. Each lane has its own output-enable bit, and that bit is registered together with the read data. A narrow-width system can therefore tri-state the lanes it does not use. A fourth pin combination turns off every output driver while the port stays selected. In that combination writes are also blocked, so the array cannot be changed.

Top module: `bmp_port_top`

## Requirements
- R1: While reset is asserted, `lane_oe` is 0000 and `rdata` is all zero.
- R2: With `{bus_match,size_sel}`=00 (long mode), a write stores all 36 bits of `wdata`. A read returns the whole stored word on `rdata[35:0]` with `lane_oe`=1111. `word_addr` and `byte_addr` have no effect.
- R3: With `{bus_match,size_sel}`=10 (word mode), a read returns a half of the stored word on `rdata[17:0]`: bits 35:18 when `word_addr`=0 and bits 17:0 when `word_addr`=1. `lane_oe` is 0011 and `rdata[35:18]` is zero.
- R4: In word mode, a write copies `wdata[17:0]` into the half selected by `word_addr` and leaves the other half unchanged. `byte_addr` has no effect.
- R5: With `{bus_match,size_sel}`=11 (byte mode), a read returns one 9-bit group on `rdata[8:0]`. The value of `{word_addr,byte_addr}` selects the group: 00 gives bits 35:27, 01 gives 26:18, 10 gives 17:9 and 11 gives 8:0. `lane_oe` is 0001 and `rdata[35:9]` is zero.
- R6: In byte mode, a write copies `wdata[8:0]` into the selected 9-bit group and leaves the other 27 bits unchanged.
- R7: With `{bus_match,size_sel}`=01 (I/O-disable mode), a read leaves `lane_oe`=0000 and `rdata` zero, and a write does not change the array.
- R8: Read data and `lane_oe` appear in the cycle after the read command. In a cycle after a cycle with no read, `lane_oe` is 0000 and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_match | input | 1 | Static width strap, high selects a narrow width |
| size_sel | input | 1 | Static width strap: byte vs word when narrow, I/O disable when wide |
| port_sel | input | 1 | Port select; a command is taken when high |
| wr_en | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Long-word address |
| word_addr | input | 1 | Half-word select in the narrow modes |
| byte_addr | input | 1 | Byte select within the half in byte mode |
| wdata | input | 4*LANE_W | Write data; the narrow modes use only the low lanes |
| rdata | output | 4*LANE_W | Read data; zero on lanes that are not enabled |
| lane_oe | output | 4 | Per-lane output enable, registered with the read data |

## Verification
The bench builds the block with `AW`=4 and the default `LANE_W`=9. With only 16 words, random narrow writes and reads hit the same addresses many times. That tests merging into words that already hold data from several earlier partial writes in both narrow widths. The 9-bit lanes keep the word- and byte-mode slice boundaries (bits 35:27, 26:18, 17:9, 8:0) at their natural positions. A wrong steering index or a wrong write-enable mask therefore changes bits that the bench can see. Mode switches between phases check that writes made in one width read back correctly in another, and that I/O-disable mode leaves the stored data as it was.

// File: rtl/bmp_pkg.sv
package bmp_pkg;

  localparam int unsigned LANES = 4;

  // Encoding is {bus_match,size_sel}
  typedef enum logic [1:0] {
    MODE_LONG = 2'b00,
    MODE_OFF  = 2'b01,
    MODE_WORD = 2'b10,
    MODE_BYTE = 2'b11
  } bmp_mode_e;

  // Lanes of the stored word touched by an access
  function automatic logic [LANES-1:0] access_mask(bmp_mode_e m, logic wa, logic ba);
    logic [1:0] grp;
    grp = 2'd3 - {wa, ba};
    case (m)
      MODE_LONG: access_mask = 4'b1111;
      MODE_WORD: access_mask = wa ? 4'b0011 : 4'b1100;
      MODE_BYTE: access_mask = 4'b0001 << grp;
      default:   access_mask = 4'b0000;
    endcase
  endfunction

  // Lowest stored lane that is mapped onto port lane 0
  function automatic logic [1:0] base_lane(bmp_mode_e m, logic wa, logic ba);
    case (m)
      MODE_WORD: base_lane = wa ? 2'd0 : 2'd2;
      MODE_BYTE: base_lane = 2'd3 - {wa, ba};
      default:   base_lane = 2'd0;
    endcase
  endfunction

  // Port lanes driven on a read
  function automatic logic [LANES-1:0] port_lanes(bmp_mode_e m);
    case (m)
      MODE_LONG: port_lanes = 4'b1111;
      MODE_WORD: port_lanes = 4'b0011;
      MODE_BYTE: port_lanes = 4'b0001;
      default:   port_lanes = 4'b0000;
    endcase
  endfunction

  // Port lane that feeds stored lane k on a write
  function automatic logic [1:0] src_lane(bmp_mode_e m, logic [1:0] k);
    case (m)
      MODE_WORD: src_lane = {1'b0, k[0]};
      MODE_BYTE: src_lane = 2'd0;
      default:   src_lane = k;
    endcase
  endfunction

endpackage

// File: rtl/bmp_mode_dec.sv
module bmp_mode_dec
  import bmp_pkg::*;
(
  input  logic      bus_match,
  input  logic      size_sel,
  output bmp_mode_e mode,
  output logic      io_off
);
  always_comb begin
    mode   = bmp_mode_e'({bus_match, size_sel});
    io_off = (mode == MODE_OFF);
  end
endmodule

// File: rtl/bmp_write_steer.sv
module bmp_write_steer
  import bmp_pkg::*;
#(
  parameter int unsigned LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  bmp_mode_e                mode,
  input  logic                     wr_req,
  input  logic                     wa,
  input  logic                     ba,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES-1:0]         lane_we,
  output logic [LANES*LANE_W-1:0]  lane_wdata
);
  assign lane_we = wr_req ? access_mask(mode, wa, ba) : '0;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] src;
    assign src = src_lane(mode, 2'(k));
    assign lane_wdata[k*LANE_W +: LANE_W] = din[src*LANE_W +: LANE_W];
  end

  a_r2_long_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && mode == MODE_LONG) |-> lane_we == 4'b1111);
  a_r4_word_half: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && mode == MODE_WORD) |-> (lane_we == 4'b0011 || lane_we == 4'b1100));
  a_r6_byte_single: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && mode == MODE_BYTE) |-> $countones(lane_we) == 1);
  a_r7_off_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_OFF) |-> lane_we == '0);
endmodule

// File: rtl/bmp_lane_ram.sv
module bmp_lane_ram
  import bmp_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned AW     = 6
) (
  input  logic                     clk,
  input  logic [AW-1:0]            addr,
  input  logic [LANES-1:0]         lane_we,
  input  logic [LANES*LANE_W-1:0]  lane_wdata,
  input  logic                     rd_en,
  output logic [LANES*LANE_W-1:0]  lane_rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar k = 0; k < LANES; k++) begin : g_bank
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (lane_we[k]) mem[addr] <= lane_wdata[k*LANE_W +: LANE_W];
      if (rd_en)      lane_rdata[k*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/bmp_read_steer.sv
module bmp_read_steer
  import bmp_pkg::*;
#(
  parameter int unsigned LANE_W = 9
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         oe_q,
  input  logic [1:0]               base_q,
  input  logic [LANES*LANE_W-1:0]  lane_rdata,
  output logic [LANES*LANE_W-1:0]  dout
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [1:0] src;
    assign src = base_q + 2'(k);
    assign dout[k*LANE_W +: LANE_W] = oe_q[k] ? lane_rdata[src*LANE_W +: LANE_W] : '0;
  end

  a_r5_oe_shape: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q == 4'b0000 || oe_q == 4'b0001 || oe_q == 4'b0011 || oe_q == 4'b1111);
endmodule

// File: rtl/bmp_port_top.sv
module bmp_port_top
  import bmp_pkg::*;
#(
  parameter int unsigned LANE_W = 9,
  parameter int unsigned AW     = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_match,
  input  logic                    size_sel,
  input  logic                    port_sel,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic                    word_addr,
  input  logic                    byte_addr,
  input  logic [4*LANE_W-1:0]     wdata,
  output logic [4*LANE_W-1:0]     rdata,
  output logic [3:0]              lane_oe
);
  localparam int unsigned DW = LANES * LANE_W;

  bmp_mode_e             mode;
  logic                  io_off;
  logic                  wr_req, rd_req;
  logic [LANES-1:0]      lane_we;
  logic [DW-1:0]         lane_wdata, lane_rdata;
  logic [LANES-1:0]      oe_q;
  logic [1:0]            base_q;

  bmp_mode_dec u_dec (
    .bus_match (bus_match),
    .size_sel  (size_sel),
    .mode      (mode),
    .io_off    (io_off)
  );

  assign wr_req = port_sel &  wr_en;
  assign rd_req = port_sel & ~wr_en & ~io_off;

  bmp_write_steer #(.LANE_W(LANE_W)) u_wst (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .wr_req     (wr_req),
    .wa         (word_addr),
    .ba         (byte_addr),
    .din        (wdata),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata)
  );

  bmp_lane_ram #(.LANE_W(LANE_W), .AW(AW)) u_ram (
    .clk        (clk),
    .addr       (addr),
    .lane_we    (lane_we),
    .lane_wdata (lane_wdata),
    .rd_en      (rd_req),
    .lane_rdata (lane_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oe_q   <= '0;
      base_q <= '0;
    end else begin
      oe_q   <= rd_req ? port_lanes(mode) : '0;
      base_q <= base_lane(mode, word_addr, byte_addr);
    end
  end

  bmp_read_steer #(.LANE_W(LANE_W)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .oe_q       (oe_q),
    .base_q     (base_q),
    .lane_rdata (lane_rdata),
    .dout       (rdata)
  );

  assign lane_oe = oe_q;

  a_r8_oe_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> lane_oe != 4'b0000);
  a_r8_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_sel && !wr_en) |=> (lane_oe == 4'b0000 && rdata == '0));
  a_r7_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    io_off |=> lane_oe == 4'b0000);
  a_r3_word_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && mode == MODE_WORD) |=> lane_oe == 4'b0011);
endmodule

// File: tb/bmp_port_top_tb_top.sv
`timescale 1ns/1ps
module bmp_port_top_tb_top;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic bus_match = 0, size_sel = 0, port_sel = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic word_addr = 0, byte_addr = 0;
  logic [35:0] wdata = '0;
  logic [35:0] rdata;
  logic [3:0]  lane_oe;

  int checks = 0, errors = 0;
  logic [35:0] model [DEPTH];

  always #2.5 clk = ~clk;

  bmp_port_top #(.LANE_W(9), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_match(bus_match), .size_sel(size_sel),
    .port_sel(port_sel), .wr_en(wr_en), .addr(addr), .word_addr(word_addr),
    .byte_addr(byte_addr), .wdata(wdata), .rdata(rdata), .lane_oe(lane_oe)
  );

  function automatic logic [39:0] exp_read(bit bm, bit sz, logic [35:0] m, bit wa, bit ba);
    logic [8:0] b;
    case ({wa, ba})
      2'b00: b = m[35:27];
      2'b01: b = m[26:18];
      2'b10: b = m[17:9];
      default: b = m[8:0];
    endcase
    case ({bm, sz})
      2'b00: return {4'hF, m};
      2'b10: return {4'h3, 18'h0, (wa ? m[17:0] : m[35:18])};
      2'b11: return {4'h1, 27'h0, b};
      default: return 40'h0;
    endcase
  endfunction

  function automatic logic [35:0] merge(bit bm, bit sz, logic [35:0] m, logic [35:0] d, bit wa, bit ba);
    logic [35:0] r;
    r = m;
    case ({bm, sz})
      2'b00: r = d;
      2'b10: if (wa) r[17:0] = d[17:0]; else r[35:18] = d[17:0];
      2'b11: case ({wa, ba})
               2'b00: r[35:27] = d[8:0];
               2'b01: r[26:18] = d[8:0];
               2'b10: r[17:9]  = d[8:0];
               default: r[8:0] = d[8:0];
             endcase
      default: r = m;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [39:0] act, logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] rnd36();
    return {$urandom, $urandom} & 36'hF_FFFF_FFFF;
  endfunction

  task automatic set_mode(bit bm, bit sz);
    @(negedge clk);
    port_sel = 0; bus_match = bm; size_sel = sz;
    @(negedge clk);
  endtask

  task automatic op(bit w, int a, bit wa, bit ba, logic [35:0] d, string tag, bit idle_chk);
    @(negedge clk);
    port_sel = 1; wr_en = w; addr = AW'(a); word_addr = wa; byte_addr = ba; wdata = d;
    @(negedge clk);
    port_sel = 0; wr_en = 0; wdata = rnd36(); word_addr = ~wa; byte_addr = ~ba;
    if (w) model[a] = merge(bus_match, size_sel, model[a], d, wa, ba);
    else check(tag, {lane_oe, rdata}, exp_read(bus_match, size_sel, model[a], wa, ba));
    if (idle_chk) begin
      @(negedge clk);
      check("R8 idle after read", {lane_oe, rdata}, 40'h0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog act=timeout exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {lane_oe, rdata}, 40'h0);
    rst_n = 1;

    // R2: long mode, address select bits randomised
    set_mode(0, 0);
    for (int a = 0; a < DEPTH; a++) op(1, a, $urandom % 2, $urandom % 2, rnd36(), "", 0);
    for (int a = 0; a < DEPTH; a++) op(0, a, $urandom % 2, $urandom % 2, 36'h0, "R2 long read", a < 2);

    // R3 R4: word mode
    set_mode(1, 0);
    op(1, 5, 0, 1, 36'h0_0003_FFFF, "", 0);
    op(0, 5, 1, 0, 36'h0, "R4 other half kept", 1);
    op(0, 5, 0, 0, 36'h0, "R3 upper half read", 0);
    for (int i = 0; i < 200; i++)
      op($urandom % 2, $urandom % DEPTH, $urandom % 2, $urandom % 2, rnd36(), "R3 R4 word random", i % 50 == 0);

    // R5 R6: byte mode
    set_mode(1, 1);
    for (int g = 0; g < 4; g++) op(1, 7, g[1], g[0], 36'(9'h100 + g), "", 0);
    for (int g = 0; g < 4; g++) op(0, 7, g[1], g[0], 36'h0, "R5 byte group read", 0);
    for (int i = 0; i < 300; i++)
      op($urandom % 2, $urandom % DEPTH, $urandom % 2, $urandom % 2, rnd36(), "R5 R6 byte random", i % 60 == 0);

    // cross-width readback in long mode
    set_mode(0, 0);
    for (int a = 0; a < DEPTH; a++) op(0, a, $urandom % 2, $urandom % 2, 36'h0, "R2 R4 R6 long readback", 0);

    // R7: I/O disable
    set_mode(0, 1);
    op(1, 3, 0, 0, 36'hA_5A5A_5A5A, "", 0);
    op(0, 3, 0, 0, 36'h0, "R7 off read silent", 1);
    set_mode(0, 0);
    op(0, 3, 0, 0, 36'h0, "R7 off write blocked", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule